// File: doc/BRIEF.md
# Microword-Driven Register Transfer Datapath

This block holds the architectural and memory-interface registers of a small microcoded 8-bit processor. It has one memory data register and one instruction register, both 8 bits wide. It has a memory address register and a program counter, both 16 bits wide. It also has four 8-bit general registers and a 16-bit stack pointer. None of these registers decides on its own when to change. Each cycle, a nine-bit slice of the current microword (bits 11 through 19) says which registers capture a new value. The slice also picks the source for the memory data register. An ALU outside this block produces the 16-bit result bus Z. External memory supplies the 8-bit data bus.

The memory data register and the memory address register also drive the memory side: they supply the data to write and the address to present. Every load takes effect on the rising clock edge that follows the microword. Several registers may be loaded in the same cycle. Address translation and the ALU sit outside the block.

The control slice is a fixed field inside the microword. The registers are plain state rather than streamed data, so every pin is a plain level-sampled signal. No valid/ready handshake is used, and nothing exerts back-pressure.

Top module: `mw_xfer_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register output (`mdr_q`, `mar_q`, `ir_q`, `pc_q`, `gpr_q`, `sp_q`) becomes zero after that edge.
- R2: When `uword[12]` is 1 and `uword[11]` is 0, `mdr_q` takes `dbus_in` at the edge.
- R3: When `uword[12]` is 1 and `uword[11]` is 1, `mdr_q` takes `z_bus[7:0]`. When `uword[12]` is 0, `mdr_q` keeps its value, whatever `uword[11]` is.
- R4: When `uword[13]` is 1, `mar_q` takes all 16 bits of `z_bus`. Otherwise it holds.
- R5: When `uword[14]` is 1, `ir_q` takes `dbus_in`. Otherwise it holds.
- R6: When `uword[15]` is 1 and `uword[16]` is 0, `pc_q` increases by one, and it wraps from 16'hFFFF to 16'h0000.
- R7: When `uword[16]` is 1, `pc_q` takes all 16 bits of `z_bus`, even if `uword[15]` is also 1. With both bits at 0, `pc_q` holds.
- R8: The destination field `uword[19:17]` selects one register to load. Codes 3'b001 to 3'b100 load general registers A to D with `z_bus[7:0]`. Register A is `gpr_q[7:0]`, B is `gpr_q[15:8]`, C is `gpr_q[23:16]` and D is `gpr_q[31:24]`. Code 3'b101 loads `sp_q` with all 16 bits of `z_bus`.
- R9: Destination codes 3'b000, 3'b110 and 3'b111 leave all general registers and `sp_q` unchanged.
- R10: Loads of different registers in the same cycle act independently of one another. Every register not addressed in a cycle keeps its value.
- R11: `mem_addr` always equals `mar_q`, and `mem_wdata` always equals `mdr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all loads happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| uword | input | 9 ([19:11]) | Register-transfer control field of the current microword |
| z_bus | input | 16 | Result bus from the ALU |
| dbus_in | input | 8 | Data read from memory |
| mdr_q | output | 8 | Memory data register |
| mar_q | output | 16 | Memory address register |
| ir_q | output | 8 | Instruction register |
| pc_q | output | 16 | Program counter |
| gpr_q | output | 32 | General registers D:C:B:A, with A in the low byte |
| sp_q | output | 16 | Stack pointer |
| mem_addr | output | 16 | Address presented to memory |
| mem_wdata | output | 8 | Data presented to memory for writes |

## Verification
The assertions assume that `uword`, `z_bus` and `dbus_in` are fully known and are settled before each rising edge. They also assume that `rst` is high from time zero until the first edge has passed. The load checks compare a register against the value its source bus had one edge earlier, and they are switched off whenever reset is high. The stimulus keeps to these conditions. It changes the inputs only on falling edges and always drives them with defined values. It holds reset from the start, and it asserts reset again only through a task that also defines every other input.

// File: rtl/mwx_pkg.sv
package mwx_pkg;

  localparam int unsigned UW_LSB   = 11;
  localparam int unsigned UW_MSB   = 19;
  localparam int unsigned UW_W     = UW_MSB - UW_LSB + 1;
  localparam int unsigned DEST_W   = 3;
  localparam int unsigned GPR_N    = 4;

  typedef enum logic [DEST_W-1:0] {
    DST_NONE = 3'd0,
    DST_GA   = 3'd1,
    DST_GB   = 3'd2,
    DST_GC   = 3'd3,
    DST_GD   = 3'd4,
    DST_STK  = 3'd5,
    DST_RSV6 = 3'd6,
    DST_RSV7 = 3'd7
  } dest_e;

  // Packed from the top microword bit down to bit 11, so a cast of the
  // nine-bit slice lines each field up with its microword position.
  typedef struct packed {
    dest_e dest;       // 19:17
    logic  pc_load;    // 16
    logic  pc_inc;     // 15
    logic  ir_load;    // 14
    logic  mar_load;   // 13
    logic  mdr_load;   // 12
    logic  mdr_from_z; // 11
  } xfer_ctl_t;

endpackage

// File: rtl/mwx_decode.sv
module mwx_decode
  import mwx_pkg::*;
#(
  parameter int unsigned NUM_GPR = GPR_N
) (
  input  logic [UW_MSB:UW_LSB] uword,
  output logic                 mdr_we,
  output logic                 mdr_sel_z,
  output logic                 mar_we,
  output logic                 ir_we,
  output logic                 pc_we,
  output logic                 pc_step,
  output logic [NUM_GPR-1:0]   gpr_we,
  output logic                 sp_we
);

  xfer_ctl_t ctl;

  always_comb begin
    ctl       = xfer_ctl_t'(uword);
    mdr_we    = ctl.mdr_load;
    mdr_sel_z = ctl.mdr_from_z;
    mar_we    = ctl.mar_load;
    ir_we     = ctl.ir_load;
    pc_we     = ctl.pc_load;
    pc_step   = ctl.pc_inc & ~ctl.pc_load;
    sp_we     = (ctl.dest == DST_STK);
  end

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_dst
    localparam logic [DEST_W-1:0] CODE = DEST_W'(g + 1);
    assign gpr_we[g] = (ctl.dest == CODE);
  end

endmodule

// File: rtl/mwx_reg.sv
module mwx_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/mwx_pc.sv
module mwx_pc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
    else if (step) q <= q + ONE;
  end

endmodule

// File: rtl/mw_xfer_datapath.sv
module mw_xfer_datapath
  import mwx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [UW_MSB:UW_LSB]      uword,
  input  logic [ADDR_W-1:0]         z_bus,
  input  logic [DATA_W-1:0]         dbus_in,
  output logic [DATA_W-1:0]         mdr_q,
  output logic [ADDR_W-1:0]         mar_q,
  output logic [DATA_W-1:0]         ir_q,
  output logic [ADDR_W-1:0]         pc_q,
  output logic [GPR_N*DATA_W-1:0]   gpr_q,
  output logic [ADDR_W-1:0]         sp_q,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata
);

  logic              mdr_we, mdr_sel_z, mar_we, ir_we, pc_we, pc_step, sp_we;
  logic [GPR_N-1:0]  gpr_we;
  logic [DATA_W-1:0] z_lo;
  logic [DATA_W-1:0] mdr_d;

  assign z_lo  = z_bus[DATA_W-1:0];
  assign mdr_d = mdr_sel_z ? z_lo : dbus_in;

  mwx_decode #(.NUM_GPR(GPR_N)) u_dec (
    .uword     (uword),
    .mdr_we    (mdr_we),
    .mdr_sel_z (mdr_sel_z),
    .mar_we    (mar_we),
    .ir_we     (ir_we),
    .pc_we     (pc_we),
    .pc_step   (pc_step),
    .gpr_we    (gpr_we),
    .sp_we     (sp_we)
  );

  mwx_reg #(.W(DATA_W)) u_mdr (
    .clk(clk), .rst(rst), .we(mdr_we), .d(mdr_d), .q(mdr_q)
  );

  mwx_reg #(.W(ADDR_W)) u_mar (
    .clk(clk), .rst(rst), .we(mar_we), .d(z_bus), .q(mar_q)
  );

  mwx_reg #(.W(DATA_W)) u_ir (
    .clk(clk), .rst(rst), .we(ir_we), .d(dbus_in), .q(ir_q)
  );

  mwx_pc #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .load(pc_we), .step(pc_step), .d(z_bus), .q(pc_q)
  );

  for (genvar g = 0; g < GPR_N; g++) begin : g_gpr
    mwx_reg #(.W(DATA_W)) u_gpr (
      .clk (clk),
      .rst (rst),
      .we  (gpr_we[g]),
      .d   (z_lo),
      .q   (gpr_q[g*DATA_W +: DATA_W])
    );
  end

  mwx_reg #(.W(ADDR_W)) u_sp (
    .clk(clk), .rst(rst), .we(sp_we), .d(z_bus), .q(sp_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

endmodule

// File: rtl/mwx_datapath_chk.sv
module mwx_datapath_chk
  import mwx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [UW_MSB:UW_LSB]    uword,
  input logic [ADDR_W-1:0]       z_bus,
  input logic [DATA_W-1:0]       dbus_in,
  input logic [DATA_W-1:0]       mdr_q,
  input logic [ADDR_W-1:0]       mar_q,
  input logic [DATA_W-1:0]       ir_q,
  input logic [ADDR_W-1:0]       pc_q,
  input logic [GPR_N*DATA_W-1:0] gpr_q,
  input logic [ADDR_W-1:0]       sp_q,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [DATA_W-1:0]       mem_wdata
);

  logic [2:0] dst;
  assign dst = uword[19:17];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mdr_q == '0 && mar_q == '0 && ir_q == '0 && pc_q == '0 &&
             gpr_q == '0 && sp_q == '0));

  assert_mdr_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (uword[12] && !uword[11]) |=> mdr_q == $past(dbus_in));

  assert_mdr_z_R3: assert property (@(posedge clk) disable iff (rst)
    (uword[12] && uword[11]) |=> mdr_q == $past(z_bus[DATA_W-1:0]));

  assert_mdr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !uword[12] |=> $stable(mdr_q));

  assert_mar_load_R4: assert property (@(posedge clk) disable iff (rst)
    uword[13] |=> mar_q == $past(z_bus));

  assert_ir_load_R5: assert property (@(posedge clk) disable iff (rst)
    uword[14] |=> ir_q == $past(dbus_in));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
    (uword[15] && !uword[16]) |=> pc_q == $past(pc_q) + ADDR_W'(1));

  assert_pc_load_R7: assert property (@(posedge clk) disable iff (rst)
    uword[16] |=> pc_q == $past(z_bus));

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!uword[15] && !uword[16]) |=> $stable(pc_q));

  for (genvar g = 0; g < GPR_N; g++) begin : g_gchk
    assert_gpr_load_R8: assert property (@(posedge clk) disable iff (rst)
      (dst == 3'(g + 1)) |=> gpr_q[g*DATA_W +: DATA_W] == $past(z_bus[DATA_W-1:0]));
  end

  assert_sp_load_R8: assert property (@(posedge clk) disable iff (rst)
    (dst == 3'd5) |=> sp_q == $past(z_bus));

  assert_no_dest_R9: assert property (@(posedge clk) disable iff (rst)
    (dst == 3'd0 || dst == 3'd6 || dst == 3'd7) |=> ($stable(gpr_q) && $stable(sp_q)));

  assert_mar_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !uword[13] |=> $stable(mar_q));

  assert_ir_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !uword[14] |=> $stable(ir_q));

  assert_mem_side_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_addr == $past(mar_q) || mem_addr == mar_q) && mem_wdata == mdr_q);

endmodule

bind mw_xfer_datapath mwx_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .uword(uword), .z_bus(z_bus), .dbus_in(dbus_in),
  .mdr_q(mdr_q), .mar_q(mar_q), .ir_q(ir_q), .pc_q(pc_q), .gpr_q(gpr_q),
  .sp_q(sp_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/mw_xfer_datapath_tb_top.sv
module mw_xfer_datapath_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [19:11] uword;
  logic [15:0] z_bus;
  logic [7:0]  dbus_in;
  logic [7:0]  mdr_q, ir_q, mem_wdata;
  logic [15:0] mar_q, pc_q, sp_q, mem_addr;
  logic [31:0] gpr_q;

  always #10 clk = ~clk;

  mw_xfer_datapath dut_i (
    .clk(clk), .rst(rst), .uword(uword), .z_bus(z_bus), .dbus_in(dbus_in),
    .mdr_q(mdr_q), .mar_q(mar_q), .ir_q(ir_q), .pc_q(pc_q), .gpr_q(gpr_q),
    .sp_q(sp_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  typedef struct packed {
    logic [7:0]  mdr;
    logic [15:0] mar;
    logic [7:0]  ir;
    logic [15:0] pc;
    logic [31:0] gpr;
    logic [15:0] sp;
  } snap_t;

  snap_t exp_q[$];
  string tag_q[$];
  snap_t model;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  function automatic logic [8:0] mw(bit sel_z, bit mdr_ld, bit mar_ld, bit ir_ld,
                                    bit pc_inc, bit pc_ld, logic [2:0] dst);
    return {dst, pc_ld, pc_inc, ir_ld, mar_ld, mdr_ld, sel_z};
  endfunction

  task automatic push(string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1; uword = 9'h1FF; z_bus = 16'hA5A5; dbus_in = 8'h5A;
    model = '0;
    push(tag);
  endtask

  task automatic step(logic [8:0] w, logic [15:0] zv, logic [7:0] dv, string tag);
    @(negedge clk);
    rst = 1'b0; uword = w; z_bus = zv; dbus_in = dv;
    if (w[1]) model.mdr = w[0] ? zv[7:0] : dv;
    if (w[2]) model.mar = zv;
    if (w[3]) model.ir = dv;
    if (w[5]) model.pc = zv;
    else if (w[4]) model.pc = model.pc + 16'd1;
    case (w[8:6])
      3'd1: model.gpr[7:0]   = zv[7:0];
      3'd2: model.gpr[15:8]  = zv[7:0];
      3'd3: model.gpr[23:16] = zv[7:0];
      3'd4: model.gpr[31:24] = zv[7:0];
      3'd5: model.sp         = zv;
      default: ;
    endcase
    push(tag);
  endtask

  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "mdr", 32'(mdr_q), 32'(e.mdr));
        chk(t, "mar", 32'(mar_q), 32'(e.mar));
        chk(t, "ir",  32'(ir_q),  32'(e.ir));
        chk(t, "pc",  32'(pc_q),  32'(e.pc));
        chk(t, "gpr", gpr_q,      e.gpr);
        chk(t, "sp",  32'(sp_q),  32'(e.sp));
        chk("R11", "mem_addr",  32'(mem_addr),  32'(e.mar));
        chk("R11", "mem_wdata", 32'(mem_wdata), 32'(e.mdr));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; uword = '0; z_bus = '0; dbus_in = '0;
    model = '0;
    do_reset("R1");
    do_reset("R1");
    step(mw(0,1,0,0,0,0,3'd0), 16'hAA55, 8'h3C, "R2");
    step(mw(1,1,0,0,0,0,3'd0), 16'h12C7, 8'h00, "R3");
    step(mw(1,0,0,0,0,0,3'd0), 16'hFFFF, 8'h11, "R3");
    step(mw(0,0,0,0,0,0,3'd0), 16'hFFFF, 8'h22, "R3");
    step(mw(0,0,1,0,0,0,3'd0), 16'hBEEF, 8'h00, "R4");
    step(mw(0,0,0,0,0,0,3'd0), 16'h0001, 8'h00, "R4");
    step(mw(0,0,0,1,0,0,3'd0), 16'h0000, 8'h9A, "R5");
    step(mw(0,0,0,0,0,1,3'd0), 16'hFFFE, 8'h00, "R7");
    step(mw(0,0,0,0,1,0,3'd0), 16'h0000, 8'h00, "R6");
    step(mw(0,0,0,0,1,0,3'd0), 16'h1234, 8'h00, "R6");
    step(mw(0,0,0,0,1,1,3'd0), 16'h4321, 8'h00, "R7");
    step(mw(0,0,0,0,0,0,3'd0), 16'h9999, 8'h00, "R7");
    step(mw(0,0,0,0,0,0,3'd1), 16'hF111, 8'h00, "R8");
    step(mw(0,0,0,0,0,0,3'd2), 16'hF222, 8'h00, "R8");
    step(mw(0,0,0,0,0,0,3'd3), 16'hF333, 8'h00, "R8");
    step(mw(0,0,0,0,0,0,3'd4), 16'hF444, 8'h00, "R8");
    step(mw(0,0,0,0,0,0,3'd5), 16'hABCD, 8'h00, "R8");
    step(mw(0,0,0,0,0,0,3'd0), 16'hFFFF, 8'h00, "R9");
    step(mw(0,0,0,0,0,0,3'd6), 16'h0000, 8'h00, "R9");
    step(mw(0,0,0,0,0,0,3'd7), 16'h5A5A, 8'h00, "R9");
    step(mw(1,1,1,1,1,1,3'd2), 16'h7E81, 8'h42, "R10");
    step(mw(0,0,0,0,0,0,3'd0), 16'h0000, 8'hFF, "R10");
    for (int i = 0; i < 300; i++) begin
      step(9'($urandom), 16'($urandom), 8'($urandom), "R10");
    end
    do_reset("R1");
    step(mw(0,0,0,0,0,0,3'd0), 16'h1111, 8'h11, "R1");
    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule